// File: doc/BRIEF.md
# Interrupt Status Aggregator with Selective Clear

This block gathers the interrupt sources of a network controller into one 32-bit status word and drives a single active-high interrupt line. Ten single-cycle event pulses are captured into sticky bits. Six level signals from sub-blocks (for example the PCS, the MACs, the management interface and the bus-error unit) are shown as live summaries. The live transmit completion index of the fourth transmit queue fills the top thirteen bits. A programmable mask decides which sources may raise the interrupt line. A summary bit in the word reflects the line, so a polling driver only has to test one bit.

Software sees the word through two read views. A read of the plain view clears every sticky event bit. A read of the alias view returns the same word but clears only the sticky bits that are selected in a separate clear-select register. The register port is a simple strobe interface with a 2-bit register select, combinational read data, and write and read strobes that act on the next rising clock edge. Fatal framing errors and the sub-block summaries are also ORed into an error indication.

Top module: `irq_status_agg`

## Requirements
- R1: An event pulse on `evt_pulse[i]` (i in 0..9) sets status bit i at the next clock edge. The bit stays set until a clearing read removes it.
- R2: Status bits [18:13] show `sub_pending[5:0]` live, with bit 13 taken from `sub_pending[0]`. No read clears them.
- R3: A read strobe with `reg_sel`=0 (plain status view) returns the status word and clears all of bits [9:0] at that clock edge.
- R4: A read with `reg_sel`=3 (alias view) returns the same word as the plain view. It clears only those bits [9:0] that are set in the clear-select register (`reg_sel`=2). That register resets to 0 and reads back what was written.
- R5: The mask register (`reg_sel`=1) uses the status bit layout, where 1 blocks a source. It resets to 0xFFFFFFFF and reads back what was written.
- R6: An event pulse that arrives in the same cycle as a clearing read leaves its bit set.
- R7: `irq_out` is registered. It is 1 one clock edge after any bit of status[18:0] (bit 12 excluded) is 1 while the matching mask bit is 0, and 0 otherwise. Status bit 12 equals `irq_out`.
- R8: Status bits [31:19] show `tx_comp_idx` live, with no latching. Bits [11:10] read as 0.
- R9: `err_pending` is 1 exactly when status bit 3, status bit 6, or any of status bits [18:13] is 1.
- R10: Writes with `reg_sel`=0 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 10 | Single-cycle event pulses for the sticky bits |
| sub_pending | input | 6 | Level summaries from the sub-blocks |
| tx_comp_idx | input | 13 | Live transmit completion index |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 clear-select, 3 alias status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears bits on the status views) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_out | output | 1 | Registered interrupt line |
| err_pending | output | 1 | Fatal error or sub-block summary present |

## Verification
The bench drives single events, several events at once, and events that coincide with clearing reads. This separates the full clear of the plain view from the selective clear of the alias view, and shows whether a colliding event is kept. Level summary inputs are raised and lowered around plain reads to show that they track their source and survive a clear. Mask patterns that block and then release one source show the one-cycle lag of the interrupt line and the summary bit. Completion index changes and error-group events separate the live fields and the error indication from the sticky bits.

// File: rtl/isa_pkg.sv
package isa_pkg;
    localparam int EVT_W  = 10;
    localparam int SUB_W  = 6;
    localparam int IDX_W  = 13;
    localparam int DATA_W = 32;
    localparam int SUM_BIT = 12;
    localparam int SUB_LSB = 13;
    localparam int SRC_W   = SUB_LSB + SUB_W;   // bits [18:0] reach the line

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_CLRSEL = 2'd2,
        SEL_ALIAS  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/isa_sticky.sv
module isa_sticky #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_i) | set_i;
    end

    assign q_o = q;

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ~clr_i) != '0) |=> ((q & $past(q & ~clr_i)) == $past(q & ~clr_i)));

    // R6
    pulse_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/isa_irq_gen.sv
module isa_irq_gen #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(src_i & ~mask_i);
    end

    assign irq_o = irq_q;

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & ~mask_i) != '0) |=> irq_o);

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & ~mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import isa_pkg::*;
#(
    parameter int P_EVT_W  = EVT_W,
    parameter int P_SUB_W  = SUB_W,
    parameter int P_IDX_W  = IDX_W,
    parameter int P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_EVT_W-1:0]  evt_pulse,
    input  logic [P_SUB_W-1:0]  sub_pending,
    input  logic [P_IDX_W-1:0]  tx_comp_idx,
    input  logic [1:0]          reg_sel,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [P_DATA_W-1:0] reg_wdata,
    output logic [P_DATA_W-1:0] reg_rdata,
    output logic                irq_out,
    output logic                err_pending
);
    localparam int SUM_POS = P_EVT_W + 2;          // summary bit
    localparam int SUB_POS = SUM_POS + 1;          // first level summary
    localparam int IDX_POS = SUB_POS + P_SUB_W;    // first index bit
    localparam int LINE_W  = IDX_POS;              // sources reaching the line
    localparam logic [P_DATA_W-1:0] ERR_GROUP =
        (P_DATA_W'(1) << 3) | (P_DATA_W'(1) << 6) |
        (((P_DATA_W'(1) << P_SUB_W) - 1) << SUB_POS);

    reg_sel_e               sel;
    logic [P_DATA_W-1:0]    mask_q;
    logic [P_DATA_W-1:0]    clrsel_q;
    logic [P_EVT_W-1:0]     sticky;
    logic [P_EVT_W-1:0]     clr_vec;
    logic [LINE_W-1:0]      line_src;
    logic [P_DATA_W-1:0]    status_word;

    assign sel = reg_sel_e'(reg_sel);

    // software-written registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            clrsel_q <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                SEL_MASK:   mask_q   <= reg_wdata;
                SEL_CLRSEL: clrsel_q <= reg_wdata;
                default:    ;
            endcase
        end
    end

    // clear vector per read view
    always_comb begin
        clr_vec = '0;
        if (reg_rd) begin
            unique case (sel)
                SEL_STATUS: clr_vec = '1;
                SEL_ALIAS:  clr_vec = clrsel_q[P_EVT_W-1:0];
                default:    clr_vec = '0;
            endcase
        end
    end

    isa_sticky #(.W(P_EVT_W)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse),
        .clr_i (clr_vec),
        .q_o   (sticky)
    );

    assign line_src = {sub_pending, 1'b0, 2'b00, sticky};

    isa_irq_gen #(.W(LINE_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (line_src),
        .mask_i (mask_q[LINE_W-1:0]),
        .irq_o  (irq_out)
    );

    assign status_word = {tx_comp_idx, sub_pending, irq_out, 2'b00, sticky};
    assign err_pending = |(status_word & ERR_GROUP);

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_word;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_CLRSEL: reg_rdata = clrsel_q;
            SEL_ALIAS:  reg_rdata = status_word;
            default:    reg_rdata = status_word;
        endcase
    end

    // R3
    plain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel == SEL_STATUS && evt_pulse == '0) |=> (sticky == '0));

    // R10
    status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && (sel == SEL_STATUS || sel == SEL_ALIAS)
         && evt_pulse == '0) |=> $stable(sticky));
endmodule

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_pulse = '0;
    logic [5:0]  sub_pending = '0;
    logic [12:0] tx_comp_idx = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic        err_pending;

    int checks = 0;
    int errors = 0;

    irq_status_agg uut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .sub_pending(sub_pending),
        .tx_comp_idx(tx_comp_idx), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
        .err_pending(err_pending)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic rd_op(input logic [1:0] s, input logic [9:0] ev, output logic [31:0] v);
        reg_sel = s; reg_rd = 1'b1; evt_pulse = ev;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; evt_pulse = '0;
    endtask

    task automatic wr_op(input logic [1:0] s, input logic [31:0] d);
        reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] ev);
        evt_pulse = ev;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(0, v); chk("R1 reset status", v, 32'h0);
        peek(1, v); chk("R5 reset mask", v, 32'hFFFF_FFFF);
        peek(2, v); chk("R4 reset clear-select", v, 32'h0);
        chk("R7 reset irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_sticky_mask();
        logic [31:0] v;
        pulse(10'h004); tick();
        peek(0, v); chk("R1 sticky bit 2", v, 32'h4);
        chk("R7 masked source no irq", {31'b0, irq_out}, 32'h0);
        wr_op(1, ~32'h4);
        peek(1, v); chk("R5 mask readback", v, ~32'h4);
        tick();
        chk("R7 unmasked source raises irq", {31'b0, irq_out}, 32'h1);
        peek(0, v); chk("R7 summary bit 12", v, 32'h1004);
    endtask

    task automatic t_plain_read();
        logic [31:0] v;
        pulse(10'h081);
        rd_op(0, 10'h0, v); chk("R3 plain read value", v, 32'h1085);
        peek(0, v); chk("R3 low bits cleared", v & 32'h3FF, 32'h0);
        tick();
        chk("R7 irq drops after clear", {31'b0, irq_out}, 32'h0);
        peek(0, v); chk("R7 summary bit clears", v, 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        pulse(10'h023);
        wr_op(2, 32'h21);
        peek(2, v); chk("R4 clear-select readback", v, 32'h21);
        rd_op(3, 10'h0, v); chk("R4 alias read value", v & 32'h3FF, 32'h23);
        peek(0, v); chk("R4 only selected bits cleared", v & 32'h3FF, 32'h2);
        rd_op(0, 10'h0, v);
        tick();
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pulse(10'h001);
        rd_op(0, 10'h010, v);
        peek(0, v); chk("R6 event kept during plain read", v & 32'h3FF, 32'h10);
        wr_op(2, 32'h10);
        rd_op(3, 10'h010, v);
        peek(0, v); chk("R6 event kept during alias read", v & 32'h3FF, 32'h10);
        rd_op(0, 10'h0, v);
        tick();
    endtask

    task automatic t_sub();
        logic [31:0] v;
        sub_pending = 6'b000101;
        #1 peek(0, v); chk("R2 level summaries shown", v, 32'h0000_A000);
        rd_op(0, 10'h0, v);
        peek(0, v); chk("R2 summaries survive read", v, 32'h0000_A000);
        wr_op(1, ~(32'h1 << 13));
        tick();
        chk("R7 unmasked summary raises irq", {31'b0, irq_out}, 32'h1);
        sub_pending = 6'b0;
        tick();
        chk("R7 irq follows summary low", {31'b0, irq_out}, 32'h0);
        peek(0, v); chk("R2 summaries follow source", v, 32'h0);
    endtask

    task automatic t_index();
        logic [31:0] v;
        tx_comp_idx = 13'h1ABC;
        #1 peek(0, v); chk("R8 index in upper bits", v, {13'h1ABC, 19'h0});
        tx_comp_idx = 13'h0005;
        #1 peek(3, v); chk("R8 index live", v, {13'h0005, 19'h0});
        tx_comp_idx = 13'h0;
    endtask

    task automatic t_err();
        logic [31:0] v;
        pulse(10'h001);
        chk("R9 plain event no error", {31'b0, err_pending}, 32'h0);
        pulse(10'h008);
        chk("R9 tx framing error", {31'b0, err_pending}, 32'h1);
        rd_op(0, 10'h0, v);
        chk("R9 error cleared", {31'b0, err_pending}, 32'h0);
        pulse(10'h040);
        chk("R9 rx framing error", {31'b0, err_pending}, 32'h1);
        rd_op(0, 10'h0, v);
        sub_pending = 6'b000100;
        #1 chk("R9 summary error", {31'b0, err_pending}, 32'h1);
        sub_pending = 6'b0;
        tick();
    endtask

    task automatic t_wr_ignored();
        logic [31:0] v;
        pulse(10'h002);
        wr_op(0, 32'hFFFF_FFFF);
        wr_op(3, 32'h0000_0000);
        peek(0, v); chk("R10 status writes ignored", v & 32'h3FF, 32'h2);
        wr_op(0, 32'h0);
        peek(0, v); chk("R10 no clear by write", v & 32'h3FF, 32'h2);
        peek(0, v); chk("R8 bits 11:10 zero", v & 32'hC00, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sticky_mask();
        t_plain_read();
        t_alias();
        t_collision();
        t_sub();
        t_index();
        t_err();
        t_wr_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule